// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a 32-bit processor. Each issued operation carries two operands, a multiply size (half-width 16x16 or full-width 32x32), an operand format (signed integer, unsigned integer or signed fractional) and a per-operation saturation enable. The product is aligned for the selected format and added into one 32-bit accumulator. The same issue port also carries operations that load the accumulator with an operand value or clear it. These travel down the same stages as multiplies, so every operation reaches the accumulator in the order it was issued.

The pipeline has three stages: operand capture, multiply, and accumulate. A half-width operation can issue on every clock. By default the full-width multiply runs as two passes through a 33x17 multiplier. It therefore holds the issue port for one extra cycle and retires one cycle later than a half-width operation. A parameter can select a single-pass full multiplier instead.

The accumulator and a sticky overflow flag are visible on output ports at all times.

Top module: `mac_pipe_top`

## Requirements
- R1: While reset is active and on the first cycle after it, `acc_value` is 0, `acc_ovf` is 0 and `issue_ready` is 1.
- R2: An operation is accepted in a cycle where `issue_valid` and `issue_ready` are both high at the rising edge. A multiply with `issue_wide`=0, a load or a clear accepted in cycle n changes `acc_value` first in cycle n+3. A multiply with `issue_wide`=1 changes it first in cycle n+4.
- R3: Half-width multiplies can be issued on consecutive cycles. `issue_ready` stays high throughout, and each one is added in turn.
- R4: After a full-width multiply (`issue_op`=0, `issue_wide`=1) is accepted, `issue_ready` is low for exactly the following cycle. Operations issued after it still update the accumulator after it.
- R5: Format codes 0 and 3 select signed integer. A half-width multiply uses bits 15:0 of each operand as two's complement and adds the 32-bit product. A full-width multiply adds bits 31:0 of the 64-bit signed product.
- R6: Format code 1 selects unsigned integer. The same bit ranges as R5 are used, treated as unsigned.
- R7: Format code 2 selects signed fractional. The product is doubled. For half-width operations all 32 bits of the doubled product are added. For full-width operations bits 62:31 of the undoubled 64-bit product are added.
- R8: `issue_op`=1 writes `opnd_a` into the accumulator. `issue_op`=2 writes 0. Both clear `acc_ovf`, and both take effect in issue order relative to multiplies.
- R9: If a multiply-accumulate overflows, `acc_ovf` is set and stays set until the next load or clear. Overflow is judged as signed for format codes 0, 2 and 3 and as unsigned for code 1. Without saturation the sum wraps modulo 2^32.
- R10: With `issue_sat`=1, an overflowing sum is clamped. In a signed format it becomes 0x7FFFFFFF for a positive addend and 0x80000000 for a negative one. In the unsigned format it becomes 0xFFFFFFFF. `acc_ovf` is still set.
- R11: `issue_op`=3, and any cycle with `issue_valid` low, leave `acc_value` and `acc_ovf` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | Operation presented this cycle |
| issue_ready | output | 1 | Operation can be accepted this cycle |
| issue_op | input | 2 | 0 multiply-accumulate, 1 load, 2 clear, 3 no operation |
| issue_wide | input | 1 | 0 half-width 16x16, 1 full-width 32x32 |
| issue_fmt | input | 2 | 0 signed integer, 1 unsigned integer, 2 signed fractional, 3 signed integer |
| issue_sat | input | 1 | Clamp on overflow for this operation |
| opnd_a | input | 32 | First multiplicand, or load value |
| opnd_b | input | 32 | Second multiplicand |
| acc_value | output | 32 | Accumulator contents |
| acc_ovf | output | 1 | Sticky accumulate overflow |

## Verification
The hardest case to reach is a full-width multiply that is still in its second multiplier pass while the next operation waits at the issue port. The accumulator must then take the two results in issue order, even though their latencies differ. The bench reaches this case by keeping `issue_valid` high across the stall cycle. It first places a half-width multiply behind a full-width one, and then a load. It samples the accumulator in each cycle to see which update lands first. Saturation and overflow corners are reached by loading the accumulator next to each limit before a single small multiply.

// File: rtl/mac_pkg.sv
package mac_pkg;

   typedef enum logic [1:0] {
      OP_MAC   = 2'd0,
      OP_LOAD  = 2'd1,
      OP_CLEAR = 2'd2,
      OP_NONE  = 2'd3
   } mac_op_e;

   typedef enum logic [1:0] {
      FMT_SINT     = 2'd0,
      FMT_UINT     = 2'd1,
      FMT_SFRAC    = 2'd2,
      FMT_SINT_ALT = 2'd3
   } mac_fmt_e;

   typedef struct packed {
      mac_op_e  op;
      logic     wide;
      mac_fmt_e fmt;
      logic     sat;
   } mac_ctl_t;

   function automatic logic fmt_is_signed(mac_fmt_e f);
      return f != FMT_UINT;
   endfunction

   function automatic logic fmt_is_frac(mac_fmt_e f);
      return f == FMT_SFRAC;
   endfunction

endpackage

// File: rtl/mac_issue_stage.sv
module mac_issue_stage
   import mac_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  mac_ctl_t          in_ctl,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   input  logic              hold,
   output logic              in_ready,
   output logic              s1_vld,
   output mac_ctl_t          s1_ctl,
   output logic [DATA_W-1:0] s1_a,
   output logic [DATA_W-1:0] s1_b
);

   logic take;

   assign in_ready = !hold;
   assign take     = in_valid && !hold && (in_ctl.op != OP_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld <= 1'b0;
         s1_ctl <= '0;
         s1_a   <= '0;
         s1_b   <= '0;
      end else if (!hold) begin
         s1_vld <= take;
         if (take) begin
            s1_ctl <= in_ctl;
            s1_a   <= in_a;
            s1_b   <= in_b;
         end
      end
   end

endmodule

// File: rtl/mac_mult_stage.sv
module mac_mult_stage
   import mac_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit SPLIT_MUL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s1_vld,
   input  mac_ctl_t          s1_ctl,
   input  logic [DATA_W-1:0] s1_a,
   input  logic [DATA_W-1:0] s1_b,
   output logic              hold,
   output logic              s2_vld,
   output mac_op_e           s2_op,
   output logic              s2_sgn,
   output logic              s2_sat,
   output logic [DATA_W-1:0] s2_word
);

   localparam int HALF_W = DATA_W / 2;
   localparam int MA_W   = DATA_W + 1;
   localparam int MB_W   = HALF_W + 1;
   localparam int MP_W   = MA_W + MB_W;
   localparam int FULL_W = 2 * DATA_W - 1;

   logic                     sgn;
   logic                     frac;
   logic                     wide;
   logic signed [MA_W-1:0]   a_ext;
   logic [FULL_W-1:0]        full_prod;
   logic [DATA_W-1:0]        aligned;
   logic [DATA_W-1:0]        word;
   logic                     advance;

   assign sgn  = fmt_is_signed(s1_ctl.fmt);
   assign frac = fmt_is_frac(s1_ctl.fmt);
   assign wide = s1_ctl.wide;

   always_comb begin
      if (wide)
         a_ext = {sgn & s1_a[DATA_W-1], s1_a};
      else
         a_ext = {{(MA_W-HALF_W){sgn & s1_a[HALF_W-1]}}, s1_a[HALF_W-1:0]};
   end

   generate
      if (SPLIT_MUL) begin : g_split
         logic                   pass_q;
         logic signed [MB_W-1:0] b_slice;
         logic signed [MP_W-1:0] mprod;
         logic signed [MP_W-1:0] part_q;
         logic [FULL_W-1:0]      mprod_x;
         logic [FULL_W-1:0]      part_x;

         always_comb begin
            if (!wide)
               b_slice = {sgn & s1_b[HALF_W-1], s1_b[HALF_W-1:0]};
            else if (!pass_q)
               b_slice = {1'b0, s1_b[HALF_W-1:0]};
            else
               b_slice = {sgn & s1_b[DATA_W-1], s1_b[DATA_W-1:HALF_W]};
         end

         assign mprod   = a_ext * b_slice;
         assign mprod_x = {{(FULL_W-MP_W){mprod[MP_W-1]}}, mprod};
         assign part_x  = {{(FULL_W-MP_W){part_q[MP_W-1]}}, part_q};

         assign full_prod = wide ? (part_x + (mprod_x << HALF_W)) : mprod_x;
         assign hold      = s1_vld && (s1_ctl.op == OP_MAC) && wide && !pass_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pass_q <= 1'b0;
               part_q <= '0;
            end else begin
               pass_q <= hold;
               if (hold)
                  part_q <= mprod;
            end
         end
      end else begin : g_single
         logic signed [MA_W-1:0]   b_ext;
         logic signed [2*MA_W-1:0] fprod;

         always_comb begin
            if (wide)
               b_ext = {sgn & s1_b[DATA_W-1], s1_b};
            else
               b_ext = {{(MA_W-HALF_W){sgn & s1_b[HALF_W-1]}}, s1_b[HALF_W-1:0]};
         end

         assign fprod     = a_ext * b_ext;
         assign full_prod = fprod[FULL_W-1:0];
         assign hold      = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!frac)
         aligned = full_prod[DATA_W-1:0];
      else if (wide)
         aligned = full_prod[FULL_W-1:DATA_W-1];
      else
         aligned = {full_prod[DATA_W-2:0], 1'b0};
   end

   always_comb begin
      unique case (s1_ctl.op)
         OP_LOAD:  word = s1_a;
         OP_MAC:   word = aligned;
         default:  word = '0;
      endcase
   end

   assign advance = s1_vld && !hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_vld  <= 1'b0;
         s2_op   <= OP_NONE;
         s2_sgn  <= 1'b0;
         s2_sat  <= 1'b0;
         s2_word <= '0;
      end else begin
         s2_vld <= advance;
         if (advance) begin
            s2_op   <= s1_ctl.op;
            s2_sgn  <= sgn;
            s2_sat  <= s1_ctl.sat;
            s2_word <= word;
         end
      end
   end

endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage
   import mac_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit HAS_SAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s2_vld,
   input  mac_op_e           s2_op,
   input  logic              s2_sgn,
   input  logic              s2_sat,
   input  logic [DATA_W-1:0] s2_word,
   output logic [DATA_W-1:0] acc_q,
   output logic              ovf_q
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W:0]   sum;
   logic              ovf_now;
   logic              sat_go;
   logic [DATA_W-1:0] clamp;

   assign sum = {1'b0, acc_q} + {1'b0, s2_word};

   always_comb begin
      if (s2_sgn) begin
         ovf_now = (acc_q[MSB] == s2_word[MSB]) && (sum[MSB] != acc_q[MSB]);
         clamp   = s2_word[MSB] ? {1'b1, {(DATA_W-1){1'b0}}}
                                : {1'b0, {(DATA_W-1){1'b1}}};
      end else begin
         ovf_now = sum[DATA_W];
         clamp   = '1;
      end
   end

   generate
      if (HAS_SAT) begin : g_sat
         assign sat_go = s2_sat;
      end else begin : g_wrap
         assign sat_go = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         ovf_q <= 1'b0;
      end else if (s2_vld) begin
         unique case (s2_op)
            OP_MAC: begin
               acc_q <= (ovf_now && sat_go) ? clamp : sum[DATA_W-1:0];
               ovf_q <= ovf_q | ovf_now;
            end
            OP_LOAD, OP_CLEAR: begin
               acc_q <= s2_word;
               ovf_q <= 1'b0;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/mac_pipe_top.sv
module mac_pipe_top
   import mac_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit SPLIT_MUL = 1'b1,
   parameter bit HAS_SAT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_valid,
   output logic              issue_ready,
   input  logic [1:0]        issue_op,
   input  logic              issue_wide,
   input  logic [1:0]        issue_fmt,
   input  logic              issue_sat,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic [DATA_W-1:0] acc_value,
   output logic              acc_ovf
);

   generate
      if ((DATA_W % 2) != 0 || DATA_W < 8) begin : g_bad_width
         $error("mac_pipe_top: DATA_W must be even and at least 8");
      end
   endgenerate

   mac_ctl_t          in_ctl;
   logic              hold;
   logic              s1_vld;
   mac_ctl_t          s1_ctl;
   logic [DATA_W-1:0] s1_a;
   logic [DATA_W-1:0] s1_b;
   logic              s2_vld;
   mac_op_e           s2_op;
   logic              s2_sgn;
   logic              s2_sat;
   logic [DATA_W-1:0] s2_word;

   assign in_ctl.op   = mac_op_e'(issue_op);
   assign in_ctl.wide = issue_wide;
   assign in_ctl.fmt  = mac_fmt_e'(issue_fmt);
   assign in_ctl.sat  = issue_sat;

   mac_issue_stage #(.DATA_W(DATA_W)) u_issue (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (issue_valid),
      .in_ctl   (in_ctl),
      .in_a     (opnd_a),
      .in_b     (opnd_b),
      .hold     (hold),
      .in_ready (issue_ready),
      .s1_vld   (s1_vld),
      .s1_ctl   (s1_ctl),
      .s1_a     (s1_a),
      .s1_b     (s1_b)
   );

   mac_mult_stage #(.DATA_W(DATA_W), .SPLIT_MUL(SPLIT_MUL)) u_mult (
      .clk     (clk),
      .rst_n   (rst_n),
      .s1_vld  (s1_vld),
      .s1_ctl  (s1_ctl),
      .s1_a    (s1_a),
      .s1_b    (s1_b),
      .hold    (hold),
      .s2_vld  (s2_vld),
      .s2_op   (s2_op),
      .s2_sgn  (s2_sgn),
      .s2_sat  (s2_sat),
      .s2_word (s2_word)
   );

   mac_acc_stage #(.DATA_W(DATA_W), .HAS_SAT(HAS_SAT)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .s2_vld  (s2_vld),
      .s2_op   (s2_op),
      .s2_sgn  (s2_sgn),
      .s2_sat  (s2_sat),
      .s2_word (s2_word),
      .acc_q   (acc_value),
      .ovf_q   (acc_ovf)
   );

endmodule

// File: rtl/mac_pipe_chk.sv
module mac_pipe_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue_valid,
   input logic              issue_ready,
   input logic [1:0]        issue_op,
   input logic              issue_wide,
   input logic [DATA_W-1:0] opnd_a,
   input logic [DATA_W-1:0] acc_value,
   input logic              acc_ovf
);

   logic              fire;
   logic              wide_mac_fire;
   logic [4:1]        eff_h;
   logic [3:1]        ld_h;
   logic [3:1]        clr_h;
   logic [DATA_W-1:0] ldv1, ldv2, ldv3;

   assign fire          = issue_valid && issue_ready && (issue_op != 2'd3);
   assign wide_mac_fire = issue_valid && issue_ready && (issue_op == 2'd0) && issue_wide;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eff_h <= '0;
         ld_h  <= '0;
         clr_h <= '0;
         ldv1  <= '0;
         ldv2  <= '0;
         ldv3  <= '0;
      end else begin
         eff_h <= {eff_h[3:1], fire};
         ld_h  <= {ld_h[2:1], issue_valid && issue_ready && (issue_op == 2'd1)};
         clr_h <= {clr_h[2:1], issue_valid && issue_ready && (issue_op == 2'd2)};
         ldv1  <= opnd_a;
         ldv2  <= ldv1;
         ldv3  <= ldv2;
      end
   end

   // R8
   load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_h[3] |-> (acc_value == ldv3) && !acc_ovf);

   // R8
   clear_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_h[3] |-> (acc_value == '0) && !acc_ovf);

   // R11
   acc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_value != $past(acc_value)) |-> (eff_h[3] || eff_h[4]));

   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(acc_ovf) |-> (ld_h[3] || clr_h[3]));

   // R4
   wide_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wide_mac_fire |=> !issue_ready);

   // R4
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_ready |-> $past(wide_mac_fire));

endmodule

bind mac_pipe_top mac_pipe_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .issue_valid (issue_valid),
   .issue_ready (issue_ready),
   .issue_op    (issue_op),
   .issue_wide  (issue_wide),
   .opnd_a      (opnd_a),
   .acc_value   (acc_value),
   .acc_ovf     (acc_ovf)
);

// File: tb/tb_mac_pipe_top.sv
module tb_mac_pipe_top;

   logic        clk;
   logic        rst_n;
   logic        issue_valid;
   logic        issue_ready;
   logic [1:0]  issue_op;
   logic        issue_wide;
   logic [1:0]  issue_fmt;
   logic        issue_sat;
   logic [31:0] opnd_a;
   logic [31:0] opnd_b;
   logic [31:0] acc_value;
   logic        acc_ovf;

   int n_chk  = 0;
   int n_fail = 0;

   mac_pipe_top dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue_valid (issue_valid),
      .issue_ready (issue_ready),
      .issue_op    (issue_op),
      .issue_wide  (issue_wide),
      .issue_fmt   (issue_fmt),
      .issue_sat   (issue_sat),
      .opnd_a      (opnd_a),
      .opnd_b      (opnd_b),
      .acc_value   (acc_value),
      .acc_ovf     (acc_ovf)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   typedef struct packed {
      logic [31:0] init;
      logic        wide;
      logic [1:0]  fmt;
      logic        sat;
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] exp;
      logic        eovf;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{32'h00000000, 1'b0, 2'd0, 1'b0, 32'hABCD0003, 32'h1234FFFE, 32'hFFFFFFFA, 1'b0},
      '{32'h0000000A, 1'b0, 2'd1, 1'b0, 32'h0000FFFF, 32'h00000002, 32'h00020008, 1'b0},
      '{32'h00000000, 1'b0, 2'd2, 1'b0, 32'h00004000, 32'h00004000, 32'h20000000, 1'b0},
      '{32'h00000000, 1'b0, 2'd2, 1'b0, 32'h00008000, 32'h00004000, 32'hC0000000, 1'b0},
      '{32'h00000005, 1'b1, 2'd0, 1'b0, 32'h00010000, 32'h00010000, 32'h00000005, 1'b0},
      '{32'h12345678, 1'b1, 2'd0, 1'b0, 32'hFFFFFFFF, 32'h12345678, 32'h00000000, 1'b0},
      '{32'h00000000, 1'b1, 2'd1, 1'b0, 32'h00010001, 32'h00010001, 32'h00020001, 1'b0},
      '{32'h00000000, 1'b1, 2'd2, 1'b0, 32'h40000000, 32'h40000000, 32'h20000000, 1'b0},
      '{32'h00000000, 1'b1, 2'd2, 1'b0, 32'h80000000, 32'h40000000, 32'hC0000000, 1'b0},
      '{32'h7FFFFFFF, 1'b0, 2'd0, 1'b0, 32'h00000001, 32'h00000001, 32'h80000000, 1'b1},
      '{32'h7FFFFFFF, 1'b0, 2'd0, 1'b1, 32'h00000001, 32'h00000001, 32'h7FFFFFFF, 1'b1},
      '{32'h80000000, 1'b0, 2'd0, 1'b0, 32'h0000FFFF, 32'h00000001, 32'h7FFFFFFF, 1'b1},
      '{32'h80000000, 1'b0, 2'd0, 1'b1, 32'h0000FFFF, 32'h00000001, 32'h80000000, 1'b1},
      '{32'hFFFFFFF0, 1'b0, 2'd1, 1'b1, 32'h00000020, 32'h00000001, 32'hFFFFFFFF, 1'b1},
      '{32'hFFFFFFF0, 1'b0, 2'd1, 1'b0, 32'h00000020, 32'h00000001, 32'h00000010, 1'b1},
      '{32'h7FFFFFFF, 1'b0, 2'd1, 1'b0, 32'h00000001, 32'h00000001, 32'h80000000, 1'b0},
      '{32'h60000000, 1'b0, 2'd2, 1'b1, 32'h00004000, 32'h00004000, 32'h7FFFFFFF, 1'b1},
      '{32'h00000000, 1'b0, 2'd3, 1'b0, 32'h0000FFFF, 32'h00000002, 32'hFFFFFFFE, 1'b0}
   };

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] op, input logic wide, input logic [1:0] fmt,
                        input logic sat, input logic [31:0] a, input logic [31:0] b);
      issue_op    = op;
      issue_wide  = wide;
      issue_fmt   = fmt;
      issue_sat   = sat;
      opnd_a      = a;
      opnd_b      = b;
      issue_valid = 1'b1;
   endtask

   task automatic send(input logic [1:0] op, input logic wide, input logic [1:0] fmt,
                       input logic sat, input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      drive(op, wide, fmt, sat, a, b);
      while (!issue_ready) @(negedge clk);
      @(negedge clk);
      issue_valid = 1'b0;
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   function automatic string vec_tag(input vec_t v);
      if (v.sat)       return "R10";
      else if (v.eovf) return "R9";
      else if (v.fmt == 2'd1) return "R6";
      else if (v.fmt == 2'd2) return "R7";
      else             return "R5";
   endfunction

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      rst_n       = 1'b0;
      issue_valid = 1'b0;
      issue_op    = 2'd0;
      issue_wide  = 1'b0;
      issue_fmt   = 2'd0;
      issue_sat   = 1'b0;
      opnd_a      = '0;
      opnd_b      = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 acc", acc_value, 32'h0);
      chk("R1 ovf", {31'h0, acc_ovf}, 32'h0);
      chk("R1 ready", {31'h0, issue_ready}, 32'h1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 acc after release", acc_value, 32'h0);

      // vector table walk
      for (int i = 0; i < NV; i++) begin
         send(2'd1, 1'b0, 2'd0, 1'b0, VECS[i].init, 32'h0);
         send(2'd0, VECS[i].wide, VECS[i].fmt, VECS[i].sat, VECS[i].a, VECS[i].b);
         settle();
         chk({vec_tag(VECS[i]), " acc"}, acc_value, VECS[i].exp);
         chk({vec_tag(VECS[i]), " ovf"}, {31'h0, acc_ovf}, {31'h0, VECS[i].eovf});
      end

      // R2 latency, half width then full width
      send(2'd1, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0);
      settle();
      @(negedge clk);
      drive(2'd0, 1'b0, 2'd0, 1'b0, 32'd2, 32'd3);
      @(negedge clk);
      issue_valid = 1'b0;
      chk("R2 n+1", acc_value, 32'd0);
      @(negedge clk);
      chk("R2 n+2", acc_value, 32'd0);
      @(negedge clk);
      chk("R2 n+3", acc_value, 32'd6);
      drive(2'd0, 1'b1, 2'd0, 1'b0, 32'd1, 32'd1);
      @(negedge clk);
      issue_valid = 1'b0;
      chk("R4 ready low", {31'h0, issue_ready}, 32'h0);
      @(negedge clk);
      chk("R4 ready back", {31'h0, issue_ready}, 32'h1);
      @(negedge clk);
      chk("R2 wide n+3", acc_value, 32'd6);
      @(negedge clk);
      chk("R2 wide n+4", acc_value, 32'd7);

      // R3 back-to-back half-width issue
      send(2'd1, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0);
      settle();
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         drive(2'd0, 1'b0, 2'd0, 1'b0, k, 32'd1);
         chk("R3 ready", {31'h0, issue_ready}, 32'h1);
         if (k >= 4) chk("R3 running sum", acc_value, (k - 3) * (k - 2) / 2);
      end
      @(negedge clk);
      issue_valid = 1'b0;
      chk("R3 sum 6", acc_value, 32'd6);
      @(negedge clk);
      chk("R3 sum 10", acc_value, 32'd10);
      @(negedge clk);
      chk("R3 sum 15", acc_value, 32'd15);

      // R4 ordering: full width followed at once by half width
      send(2'd1, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0);
      settle();
      @(negedge clk);
      drive(2'd0, 1'b1, 2'd0, 1'b0, 32'd2, 32'd3);
      @(negedge clk);
      chk("R4 stall", {31'h0, issue_ready}, 32'h0);
      drive(2'd0, 1'b0, 2'd0, 1'b0, 32'd1, 32'd1);
      @(negedge clk);
      chk("R4 resume", {31'h0, issue_ready}, 32'h1);
      @(negedge clk);
      issue_valid = 1'b0;
      chk("R4 before wide", acc_value, 32'd0);
      @(negedge clk);
      chk("R4 wide first", acc_value, 32'd6);
      @(negedge clk);
      chk("R4 half second", acc_value, 32'd7);

      // R8 load queued behind a full-width multiply
      @(negedge clk);
      drive(2'd0, 1'b1, 2'd0, 1'b0, 32'd5, 32'd5);
      @(negedge clk);
      drive(2'd1, 1'b0, 2'd0, 1'b0, 32'h100, 32'h0);
      @(negedge clk);
      @(negedge clk);
      issue_valid = 1'b0;
      settle();
      chk("R8 load after wide", acc_value, 32'h100);

      // R8 multiply directly behind a load
      @(negedge clk);
      drive(2'd1, 1'b0, 2'd0, 1'b0, 32'h200, 32'h0);
      @(negedge clk);
      drive(2'd0, 1'b0, 2'd0, 1'b0, 32'd1, 32'd1);
      @(negedge clk);
      issue_valid = 1'b0;
      settle();
      chk("R8 mac after load", acc_value, 32'h201);

      // R9 sticky flag, R11 ignored operations
      send(2'd1, 1'b0, 2'd0, 1'b0, 32'h7FFFFFFF, 32'h0);
      send(2'd0, 1'b0, 2'd0, 1'b0, 32'd1, 32'd1);
      settle();
      chk("R9 set", {31'h0, acc_ovf}, 32'h1);
      send(2'd0, 1'b0, 2'd0, 1'b0, 32'd0, 32'd0);
      settle();
      chk("R9 stays set", {31'h0, acc_ovf}, 32'h1);
      send(2'd3, 1'b0, 2'd0, 1'b0, 32'h55, 32'h3);
      settle();
      chk("R11 op3 acc", acc_value, 32'h80000000);
      chk("R11 op3 ovf", {31'h0, acc_ovf}, 32'h1);
      @(negedge clk);
      drive(2'd1, 1'b0, 2'd0, 1'b0, 32'h99, 32'h0);
      issue_valid = 1'b0;
      settle();
      chk("R11 invalid acc", acc_value, 32'h80000000);
      chk("R11 invalid ovf", {31'h0, acc_ovf}, 32'h1);
      send(2'd2, 1'b0, 2'd0, 1'b0, 32'h77, 32'h0);
      settle();
      chk("R8 clear acc", acc_value, 32'h0);
      chk("R8 clear ovf", {31'h0, acc_ovf}, 32'h0);
      send(2'd1, 1'b0, 2'd0, 1'b0, 32'h7FFFFFFF, 32'h0);
      send(2'd0, 1'b0, 2'd0, 1'b0, 32'd1, 32'd1);
      send(2'd1, 1'b0, 2'd0, 1'b0, 32'h1234, 32'h0);
      settle();
      chk("R8 load acc", acc_value, 32'h1234);
      chk("R8 load ovf", {31'h0, acc_ovf}, 32'h0);

      report();
      $finish;
   end

endmodule